// File: doc/BRIEF.md
# Bouncing Bar Step Sequencer

This block drives six lamp outputs through a fixed light pattern of fifteen steps. A bar of lit lamps grows from the low end of the row and slides to the high end. It then shrinks back into the top lamp, grows again and slides back down to the low end. The bar is never wider than three lamps. An internal step timer advances the pattern. Every step lasts the same number of clock cycles, set by a parameter.

After a reset the lamps are dark and the sequencer waits. A single start pulse arms it. From then on it runs with no further input. After the last step it goes back to the second step, so the lone bottom lamp of step 1 shows only once after each start. Reset is synchronous and active high, and it wins over start. A start pulse that arrives while the sequence is running is ignored.

Top module: `bar_seq_top`

## Requirements
- R1: While `rst` is high at a rising edge, all lamps are dark from that edge on, and they stay dark after `rst` falls until a new start is accepted.
- R2: A start pulse taken at edge E0 in the idle state leaves the lamps dark through edge E0+STEP_CYCLES-1. Step 1 appears at edge E0+STEP_CYCLES.
- R3: Every step holds for exactly STEP_CYCLES clock cycles. Lamps change only at step boundaries.
- R4: Bit n of `lamps` is lamp n. Step 1 lights lamp 0, step 2 lights lamps 0-1 and step 3 lights lamps 0-2.
- R5: Step 4 lights lamps 1-3, step 5 lights lamps 2-4, step 6 lights lamps 3-5, step 7 lights lamps 4-5 and step 8 lights lamp 5 alone.
- R6: Step 9 lights lamps 4-5, step 10 lights lamps 3-5, step 11 lights lamps 2-4, step 12 lights lamps 1-3, step 13 lights lamps 0-2, step 14 lights lamps 0-1 and step 15 lights lamp 0 alone.
- R7: The step after step 15 is step 2 (lamps 0-1), and the cycle of steps 2 to 15 repeats without end.
- R8: When `rst` and `start` are both high at the same edge, reset wins: the lamps stay dark and no sequence begins.
- R9: A start pulse while running has no effect. The pattern and its step timing continue unchanged.
- R10: At most three lamps are lit at any time, and while a step is showing at least one lamp is lit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Arms the sequence when idle |
| lamps | output | N_LAMPS | Lamp drive, bit n is lamp n |

## Verification
A wrong step counter shows up at the lamps at the next step boundary, within STEP_CYCLES cycles. A bad wrap shows up as lamp 0 alone where lamps 0-1 should be. A timer that is off by one moves every later boundary by one cycle, so the per-cycle comparison against the arithmetic model catches it at the first step. A lost run flag, or a start pulse that restarts the timer, shows as dark lamps or a shifted boundary right after the stray pulse.

// File: rtl/bar_seq_pkg.sv
package bar_seq_pkg;

    localparam int LAMPS_DEF = 6;
    localparam int BAR_DEF   = 3;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_mode_e;

    typedef struct packed {
        int lo;
        int hi;
    } span_t;

    function automatic int fwd_steps(input int n, input int w);
        return n + w - 1;
    endfunction

    function automatic int total_steps(input int n, input int w);
        return 2 * fwd_steps(n, w) - 1;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    // Lit range for a step; step 0 is an empty span.
    function automatic span_t bar_span(input int step, input int n, input int w);
        span_t sp;
        int    f;
        int    t;
        f = fwd_steps(n, w);
        if (step <= 0) begin
            sp.lo = 1;
            sp.hi = 0;
        end else if (step <= f) begin
            sp.lo = imax(step - w, 0);
            sp.hi = imin(step - 1, n - 1);
        end else begin
            t     = step - (f - 1);
            sp.lo = (n - 1) - imin(t - 1, n - 1);
            sp.hi = (n - 1) - imax(t - w, 0);
        end
        return sp;
    endfunction

endpackage

// File: rtl/bar_step_timer.sv
module bar_step_timer #(
    parameter int STEP_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(STEP_CYCLES > 1 ? STEP_CYCLES : 2);
    localparam logic [CW-1:0] LAST = CW'(STEP_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || arm) begin
            cnt_q <= '0;
        end else if (run) begin
            if (cnt_q == LAST) cnt_q <= '0;
            else               cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/bar_step_ctrl.sv
module bar_step_ctrl
    import bar_seq_pkg::*;
#(
    parameter int N_STEPS = 15,
    parameter int STEP_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              tick,
    output logic              arm,
    output logic              run,
    output logic [STEP_W-1:0] step
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(N_STEPS);
    localparam logic [STEP_W-1:0] RESUME    = STEP_W'(2);

    seq_mode_e         mode_q;
    logic [STEP_W-1:0] step_q;

    assign arm = start && !rst && (mode_q == SEQ_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= SEQ_IDLE;
        end else if (arm) begin
            mode_q <= SEQ_RUN;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || arm) begin
            step_q <= '0;
        end else if (tick) begin
            if (step_q == LAST_STEP) step_q <= RESUME;
            else                     step_q <= step_q + 1'b1;
        end
    end

    assign run  = (mode_q == SEQ_RUN);
    assign step = step_q;
endmodule

// File: rtl/bar_lamp_decode.sv
module bar_lamp_decode
    import bar_seq_pkg::*;
#(
    parameter int N_LAMPS = 6,
    parameter int BAR_MAX = 3,
    parameter int STEP_W  = 4
) (
    input  logic [STEP_W-1:0]  step,
    output logic [N_LAMPS-1:0] lamps
);
    span_t sp;

    always_comb begin
        sp = bar_span(int'(step), N_LAMPS, BAR_MAX);
    end

    for (genvar i = 0; i < N_LAMPS; i++) begin : g_lamp
        assign lamps[i] = (i >= sp.lo) && (i <= sp.hi);
    end
endmodule

// File: rtl/bar_seq_top.sv
module bar_seq_top
    import bar_seq_pkg::*;
#(
    parameter int STEP_CYCLES = 4,
    parameter int N_LAMPS     = LAMPS_DEF,
    parameter int BAR_MAX     = BAR_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    output logic [N_LAMPS-1:0] lamps
);
    localparam int N_STEPS = 2 * (N_LAMPS + BAR_MAX - 1) - 1;
    localparam int STEP_W  = $clog2(N_STEPS + 1);

    logic              arm_w;
    logic              run_w;
    logic              tick_w;
    logic [STEP_W-1:0] step_w;

    bar_step_timer #(.STEP_CYCLES(STEP_CYCLES)) u_timer (
        .clk (clk),
        .rst (rst),
        .arm (arm_w),
        .run (run_w),
        .tick(tick_w)
    );

    bar_step_ctrl #(.N_STEPS(N_STEPS), .STEP_W(STEP_W)) u_ctrl (
        .clk  (clk),
        .rst  (rst),
        .start(start),
        .tick (tick_w),
        .arm  (arm_w),
        .run  (run_w),
        .step (step_w)
    );

    bar_lamp_decode #(.N_LAMPS(N_LAMPS), .BAR_MAX(BAR_MAX), .STEP_W(STEP_W)) u_dec (
        .step (step_w),
        .lamps(lamps)
    );
endmodule

// File: rtl/bar_seq_checker.sv
module bar_seq_checker #(
    parameter int N_LAMPS = 6,
    parameter int BAR_MAX = 3,
    parameter int N_STEPS = 15,
    parameter int STEP_W  = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic               run,
    input logic               tick,
    input logic [STEP_W-1:0]  step,
    input logic [N_LAMPS-1:0] lamps
);
    p_reset_dark_r1: assert property (@(posedge clk) rst |=> (lamps == '0) && !run);

    p_idle_dark_r1: assert property (@(posedge clk) disable iff (rst)
        !run |-> (lamps == '0));

    p_hold_between_ticks_r3: assert property (@(posedge clk) disable iff (rst)
        (run && !tick && !start) |=> $stable(lamps));

    p_wrap_resume_r7: assert property (@(posedge clk) disable iff (rst)
        (tick && step == STEP_W'(N_STEPS)) |=> (step == STEP_W'(2)));

    p_reset_beats_start_r8: assert property (@(posedge clk)
        (rst && start) |=> !run);

    p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (run && start) |=> run && ($past(tick) || $stable(step)));

    p_bar_width_r10: assert property (@(posedge clk) disable iff (rst)
        $countones(lamps) <= BAR_MAX);

    p_lit_when_showing_r10: assert property (@(posedge clk) disable iff (rst)
        (step != '0) |-> (lamps != '0));
endmodule

bind bar_seq_top bar_seq_checker #(
    .N_LAMPS(N_LAMPS),
    .BAR_MAX(BAR_MAX),
    .N_STEPS(N_STEPS),
    .STEP_W (STEP_W)
) u_chk (
    .clk  (clk),
    .rst  (rst),
    .start(start),
    .run  (run_w),
    .tick (tick_w),
    .step (step_w),
    .lamps(lamps)
);

// File: tb/test_bar_seq_top.sv
module test_bar_seq_top;
    localparam int P = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [5:0] lamps;

    int n_run  = 0;
    int n_fail = 0;

    bar_seq_top #(.STEP_CYCLES(P)) i_bar_seq_top (
        .clk  (clk),
        .rst  (rst),
        .start(start),
        .lamps(lamps)
    );

    always #4 clk = ~clk;

    function automatic logic [5:0] model(input int k);
        int e;
        int s;
        int lo;
        int hi;
        logic [5:0] m;
        e = k / P;
        m = '0;
        if (e == 0) return m;
        s = (e <= 15) ? e : 2 + ((e - 2) % 14);
        if (s <= 8) begin
            lo = (s - 3 > 0) ? s - 3 : 0;
            hi = (s - 1 < 5) ? s - 1 : 5;
        end else begin
            lo = (13 - s > 0) ? 13 - s : 0;
            hi = (15 - s < 5) ? 15 - s : 5;
        end
        for (int b = lo; b <= hi; b++) m[b] = 1'b1;
        return m;
    endfunction

    function automatic string tag(input int k);
        int e;
        e = k / P;
        if (e == 0)        return "R2";
        if (k % P != 0)    return "R3";
        if (e > 15)        return "R7";
        if (e <= 3)        return "R4";
        if (e <= 8)        return "R5";
        return "R6";
    endfunction

    task automatic check(input string req, input logic [5:0] exp);
        n_run++;
        if (lamps !== exp) begin
            n_fail++;
            $display("FAIL %s: lamps=%b expected=%b", req, lamps, exp);
        end
        n_run++;
        if ($countones(lamps) > 3) begin
            n_fail++;
            $display("FAIL R10: lamps=%b expected at most 3 lit", lamps);
        end
    endtask

    task automatic pulse_start_and_track(input int cycles, input int stray_at);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R2", model(0));
        for (int k = 1; k <= cycles; k++) begin
            if (k == stray_at) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            if (stray_at > 0 && k > stray_at) check("R9", model(k));
            else                             check(tag(k), model(k));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", 6'b0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check("R1", 6'b0);

        // Full run over two wraps, stray start mid-run.
        pulse_start_and_track(P * 32, P * 20 + 1);

        // Reset mid-run darkens and stays dark.
        rst = 1'b1;
        @(negedge clk);
        check("R1", 6'b0);
        rst = 1'b0;
        for (int i = 0; i < 2 * P + 2; i++) begin
            @(negedge clk);
            check("R1", 6'b0);
        end

        // Reset together with start.
        rst = 1'b1;
        start = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        start = 1'b0;
        for (int i = 0; i < 2 * P + 2; i++) begin
            @(negedge clk);
            check("R8", 6'b0);
        end

        // Fresh start after reset begins at step 1 again.
        pulse_start_and_track(P * 18, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule